// File: doc/BRIEF.md
# Power-up configuration loader

After reset the block fills a 16-bit start-up configuration word once and then holds it. A three-level strap, decoded outside the block into a two-bit code, picks where the word comes from. In master mode the block clocks a 3-wire serial EEPROM: it raises chip select, shifts out a read command with a fixed word address and then shifts in sixteen data bits. In slave mode an external controller supplies both clock and data, and the block takes the first sixteen rising clock edges. In wired mode no serial traffic occurs and the word is all zeros.

Both serial modes deliver the least-significant bit first. Once the word is loaded, `done_o` rises and the PHY address, isolate-disable and repeater outputs are frozen until the next reset. Before `done_o` rises, every configuration output reads zero.

Top module: `cfg_loader`

## Requirements
- R1: The strap `mode_i` is sampled once, on the first clock after reset is released. The codes are 2'b00 wired, 2'b01 slave, and 2'b10 or 2'b11 master. Later changes to `mode_i` have no effect until the next reset.
- R2: In wired mode `done_o` rises within 4 clocks of reset release. The loaded word is 0, and `ser_cs_o` and `ser_clk_o` stay low.
- R3: In master mode `ser_cs_o` is high while the transfer runs. `ser_clk_o` first stays low for CLK_HALF clocks, and every high phase lasts CLK_HALF clocks. Exactly 25 clock pulses are produced.
- R4: In master mode `ser_cmd_o` is stable during each high phase. At the rising edges of pulses 1 to 9 it carries 1, 1, 0 and then EE_ADDR[5:0] MSB first, with EE_ADDR defaulting to 0.
- R5: In master mode `ser_din_i` is sampled on the falling edge of pulses 10 to 25, which is CLK_HALF clocks (1 us by default) after the rise. The bit taken at pulse 10 becomes word bit 0 and the bit taken at pulse 25 becomes bit 15.
- R6: In slave mode `ser_clk_i` and `ser_din_i` pass through two-flop synchronisers. The first 16 rising edges of `ser_clk_i` each capture one bit, the first into word bit 0. `done_o` stays low until the 16th edge.
- R7: `phy_addr_o` = word[15:11], `iso_dis_o` = word[7] and `repeater_o` = word[6]. The other word bits are discarded.
- R8: While `done_o` is low all configuration outputs are 0. `done_o` never falls before reset. After `done_o` rises, further serial activity leaves the outputs unchanged.
- R9: In master mode, after the 25th pulse `ser_cs_o` returns low and `ser_clk_o` produces no further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Decoded strap level: 00 wired, 01 slave, 1x master |
| ser_clk_i | input | 1 | Serial clock from an external controller (slave mode) |
| ser_din_i | input | 1 | Serial data from the EEPROM or controller |
| ser_clk_o | output | 1 | Generated serial clock to the EEPROM |
| ser_cs_o | output | 1 | EEPROM chip select |
| ser_cmd_o | output | 1 | Command/address bits to the EEPROM |
| phy_addr_o | output | 5 | Loaded PHY address |
| iso_dis_o | output | 1 | Loaded isolate-disable flag |
| repeater_o | output | 1 | Loaded repeater flag |
| done_o | output | 1 | Configuration loaded |

## Verification
The hardest case to reach is a late EEPROM data bit. The bench's EEPROM model first drives the inverse of each data bit after the clock rises and only moves to the true value 200 system clocks later. A loader that samples too early therefore loads a visibly wrong word. Frozen outputs need activity after load: the bench sends extra slave clocks with all-ones data and swaps the strap after sampling, then watches the outputs stay put every cycle.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    BOOT_WIRED  = 2'b00,
    BOOT_SLAVE  = 2'b01,
    BOOT_MASTER = 2'b10
  } boot_mode_e;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned CMD_W  = 9;
  localparam int unsigned ADDR_W = 6;

  function automatic boot_mode_e decode_mode(input logic [1:0] m);
    if (m[1])      return BOOT_MASTER;
    else if (m[0]) return BOOT_SLAVE;
    else           return BOOT_WIRED;
  endfunction
endpackage

// File: rtl/cfg_sclk_div.sv
module cfg_sclk_div #(
  parameter int unsigned HALF = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ee_master.sv
module cfg_ee_master
  import cfg_loader_pkg::*;
#(
  parameter int unsigned       HALF    = 250,
  parameter logic [ADDR_W-1:0] EE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              din_i,
  output logic              sclk_o,
  output logic              cs_o,
  output logic              cmd_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int unsigned TOTAL = CMD_W + WORD_W;
  localparam int unsigned PW    = $clog2(TOTAL + 1);

  logic              run_q, fin_q, sclk_q, cs_q, tick;
  logic [PW-1:0]     pulses_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] sh_q;

  cfg_sclk_div #(.HALF(HALF)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run_q), .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; fin_q <= 1'b0; sclk_q <= 1'b0; cs_q <= 1'b0;
      pulses_q <= '0; cmd_q <= '0; sh_q <= '0;
    end else if (start_i && !run_q && !fin_q) begin
      run_q <= 1'b1;
      cs_q  <= 1'b1;
      cmd_q <= {1'b1, 2'b10, EE_ADDR};
    end else if (run_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        // falling edge: data is long valid, command advances
        sclk_q   <= 1'b0;
        pulses_q <= pulses_q + 1'b1;
        cmd_q    <= {cmd_q[CMD_W-2:0], 1'b0};
        if (pulses_q >= PW'(CMD_W)) sh_q <= {din_i, sh_q[WORD_W-1:1]};
        if (pulses_q == PW'(TOTAL - 1)) begin
          run_q <= 1'b0;
          cs_q  <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_o   = cs_q;
  assign cmd_o  = run_q & cmd_q[CMD_W-1];
  assign word_o = sh_q;
  assign done_o = fin_q;

  p_clk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o);
  p_cmd_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> (!sclk_o || $stable(cmd_o)));
  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !cs_o);
endmodule

// File: rtl/cfg_slave_cap.sv
module cfg_slave_cap
  import cfg_loader_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);

  logic [2:0]        clk_s_q;
  logic [1:0]        din_s_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              rise;

  assign rise = clk_s_q[1] & ~clk_s_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_s_q <= '0; din_s_q <= '0; cnt_q <= '0; sh_q <= '0;
    end else begin
      clk_s_q <= {clk_s_q[1:0], sclk_i};
      din_s_q <= {din_s_q[0], din_i};
      if (en_i && rise && (cnt_q < CW'(WORD_W))) begin
        sh_q  <= {din_s_q[1], sh_q[WORD_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o = sh_q;
  assign done_o = (cnt_q == CW'(WORD_W));

  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WORD_W));
  p_word_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(word_o));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned       CLK_HALF = 250,
  parameter logic [ADDR_W-1:0] EE_ADDR  = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       ser_clk_i,
  input  logic       ser_din_i,
  output logic       ser_clk_o,
  output logic       ser_cs_o,
  output logic       ser_cmd_o,
  output logic [4:0] phy_addr_o,
  output logic       iso_dis_o,
  output logic       repeater_o,
  output logic       done_o
);
  boot_mode_e        mode_q;
  logic              sampled_q, done_q;
  logic [4:0]        phy_q;
  logic              iso_q, rep_q;
  logic [WORD_W-1:0] m_word, s_word, sel_word;
  logic              m_done, s_done, sel_done;
  logic              unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sampled_q <= 1'b0;
      mode_q    <= BOOT_WIRED;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      mode_q    <= decode_mode(mode_i);
    end
  end

  cfg_ee_master #(.HALF(CLK_HALF), .EE_ADDR(EE_ADDR)) u_master (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(sampled_q && (mode_q == BOOT_MASTER)),
    .din_i(ser_din_i), .sclk_o(ser_clk_o), .cs_o(ser_cs_o),
    .cmd_o(ser_cmd_o), .word_o(m_word), .done_o(m_done)
  );

  cfg_slave_cap u_slave (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(sampled_q && (mode_q == BOOT_SLAVE)),
    .sclk_i(ser_clk_i), .din_i(ser_din_i),
    .word_o(s_word), .done_o(s_done)
  );

  always_comb begin
    unique case (mode_q)
      BOOT_MASTER: begin sel_done = m_done; sel_word = m_word; end
      BOOT_SLAVE:  begin sel_done = s_done; sel_word = s_word; end
      default:     begin sel_done = 1'b1;   sel_word = '0;     end
    endcase
  end

  assign unused_bits = ^{sel_word[10:8], sel_word[5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; phy_q <= '0; iso_q <= 1'b0; rep_q <= 1'b0;
    end else if (sampled_q && !done_q && sel_done) begin
      done_q <= 1'b1;
      phy_q  <= sel_word[15:11];
      iso_q  <= sel_word[7];
      rep_q  <= sel_word[6];
    end
  end

  assign phy_addr_o = phy_q;
  assign iso_dis_o  = iso_q;
  assign repeater_o = rep_q;
  assign done_o     = done_q;

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(mode_q));
  p_defaults_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (phy_addr_o == 5'd0 && !iso_dis_o && !repeater_o));
  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(phy_addr_o) && $stable(iso_dis_o) && $stable(repeater_o)));
  p_wired_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled_q && mode_q == BOOT_WIRED) |-> !ser_cs_o);
endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int HALF = 250;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sclk_in = 1'b0, din = 1'b0;
  logic       ser_clk_o, ser_cs_o, ser_cmd_o, iso_dis_o, repeater_o, done_o;
  logic [4:0] phy_addr_o;

  int checks = 0, errors = 0;
  logic [15:0] exp_word = '0;
  logic        prev_done = 1'b0;

  always #2 clk = ~clk;

  cfg_loader #(.CLK_HALF(HALF)) u_cfg_loader (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .ser_clk_i(sclk_in), .ser_din_i(din),
    .ser_clk_o(ser_clk_o), .ser_cs_o(ser_cs_o), .ser_cmd_o(ser_cmd_o),
    .phy_addr_o(phy_addr_o), .iso_dis_o(iso_dis_o),
    .repeater_o(repeater_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: outputs are defaults until done, then the expected word's fields
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (done_o) begin
        chk("R7", phy_addr_o, exp_word[15:11], "phy address");
        chk("R7", iso_dis_o, exp_word[7], "isolate disable");
        chk("R7", repeater_o, exp_word[6], "repeater");
      end else begin
        chk("R8", {phy_addr_o, iso_dis_o, repeater_o}, 0, "defaults before done");
      end
      if (prev_done) chk("R8", done_o, 1, "done sticky");
      prev_done = done_o;
    end else prev_done = 1'b0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic do_reset(input logic [1:0] m, input logic [15:0] w);
    rst_ni = 1'b0; sclk_in = 1'b0; din = 1'b0; mode = m; exp_word = w;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic ee_run(input logic [15:0] w);
    int rises = 0, hi = 0, dly = 0, bi = 0, extra = 0;
    logic prev = 1'b0;
    logic [8:0] cmd_got = '0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (ser_clk_o && !prev) begin
        rises++;
        hi = 0;
        if (rises <= 9) cmd_got[9 - rises] = ser_cmd_o;
        if (rises >= 10) begin bi = rises - 10; din = ~w[bi]; dly = 200; end
      end
      if (ser_clk_o) hi++;
      if (!ser_clk_o && prev && rises == 1) chk("R3", hi, HALF, "high phase width");
      if (dly > 0) begin dly--; if (dly == 0) din = w[bi]; end
      if (rises == 1 && ser_clk_o && !prev) chk("R3", ser_cs_o, 1, "chip select during transfer");
      prev = ser_clk_o;
      if (done_o) break;
    end
    chk("R3", rises, 25, "pulse count");
    chk("R4", cmd_got, 9'b110_000000, "command bits");
    chk("R5", done_o, 1, "load complete");
    for (int n = 0; n < 1000; n++) begin
      @(negedge clk);
      if (ser_clk_o && !prev) extra++;
      prev = ser_clk_o;
    end
    chk("R9", extra, 0, "clock edges after load");
    chk("R9", ser_cs_o, 0, "chip select after load");
  endtask

  task automatic sl_edge(input logic b);
    din = b;
    repeat (500) @(negedge clk);
    sclk_in = 1'b1;
    repeat (500) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    chk("R8", done_o, 0, "done in reset");
    chk("R8", {phy_addr_o, iso_dis_o, repeater_o}, 0, "outputs in reset");

    // wired mode
    do_reset(2'b00, 16'h0000);
    repeat (4) @(negedge clk);
    chk("R2", done_o, 1, "wired done");
    chk("R2", {ser_cs_o, ser_clk_o}, 0, "wired serial idle");
    mode = 2'b10;
    repeat (1000) @(negedge clk);
    chk("R1", {ser_cs_o, ser_clk_o}, 0, "strap change ignored");
    for (int i = 0; i < 20; i++) sl_edge(1'b1);
    chk("R8", {phy_addr_o, iso_dis_o, repeater_o}, 0, "wired frozen");

    // master mode, two words
    do_reset(2'b10, 16'hA8C0);
    ee_run(16'hA8C0);
    chk("R5", {phy_addr_o, iso_dis_o, repeater_o}, {5'b10101, 2'b11}, "master word A");
    do_reset(2'b11, 16'h5780);
    ee_run(16'h5780);
    chk("R5", {phy_addr_o, iso_dis_o, repeater_o}, {5'b01010, 2'b10}, "master word B");

    // slave mode with trailing edges and strap change
    do_reset(2'b01, 16'h3B40);
    @(negedge clk); mode = 2'b00;
    for (int i = 0; i < 15; i++) sl_edge(exp_word[i]);
    repeat (10) @(negedge clk);
    chk("R6", done_o, 0, "not done after 15 edges");
    sl_edge(exp_word[15]);
    repeat (10) @(negedge clk);
    chk("R6", done_o, 1, "done after 16 edges");
    chk("R6", {phy_addr_o, iso_dis_o, repeater_o}, {5'b00111, 2'b01}, "slave word");
    for (int i = 0; i < 4; i++) sl_edge(1'b1);
    chk("R8", {phy_addr_o, iso_dis_o, repeater_o}, {5'b00111, 2'b01}, "extra edges ignored");
    chk("R1", ser_cs_o, 0, "strap change after sample");

    do_reset(2'b01, 16'hF880);
    for (int i = 0; i < 16; i++) sl_edge(exp_word[i]);
    repeat (10) @(negedge clk);
    chk("R6", {phy_addr_o, iso_dis_o, repeater_o}, {5'b11111, 2'b10}, "slave word 2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule